// File: doc/BRIEF.md
# DMA Peripheral Request Handshake Unit

This block sits between one DMA channel and the peripheral that paces it. The peripheral posts transfer requests, each tagged single or burst, over a valid/ready handshake. The unit holds them in a small request queue and serves three channel-side commands.

A wait-for-burst command halts the channel until a burst request reaches the head of the queue. Any single requests found at the head while waiting are thrown away. An arm-acknowledge command, for a load or a store, makes the unit signal the peripheral when the matching bus transaction completes. A flush command empties the queue and sends the peripheral a flush request. It then discards every new request until the peripheral answers, so that both sides restart from a known point.

The unit only observes completion, through the read-last beat and the write response. It does not issue bus transactions, decode instructions or move data.

Top module: `dma_preq_unit`

## Requirements
- R1: After reset, `preq_ready` is 1, `fifo_empty` is 1, `fifo_full` is 0, `halt` is 0 and `ack_valid` is 0.
- R2: A request is taken into the queue in a cycle where `preq_valid` and `preq_ready` are both 1. `preq_kind` 0 means single and 1 means burst. Entries leave the queue in arrival order. After `REQ_DEPTH` (default 4) entries are held, `fifo_full` is 1 and `preq_ready` is 0, so further requests wait and are not lost.
- R3: `halt` is 1 in the same cycle that `cmd_wfb` is 1. It stays 1 while the wait is in progress.
- R4: While waiting, a single request at the head is removed, one per cycle, and `halt` stays 1.
- R5: While waiting, a burst request at the head is removed on that clock edge, and `halt` is 0 from the next cycle on.
- R6: Once a load acknowledge is armed, `ack_valid` is 1 in the cycle where `rvalid` and `rlast` are both 1. In that cycle `ack_type` is 2'b00 if the armed kind was single and 2'b01 if it was burst. `rvalid` without `rlast` gives no acknowledge.
- R7: Once a store acknowledge is armed, `ack_valid` is 1 with the same type coding in the cycle where `bvalid` is 1. A read-last beat does not trigger a store acknowledge.
- R8: One acknowledge is held pending at a time. It fires once and is then spent. A later arm command replaces an earlier one that has not fired, and when both arm commands come in the same cycle the store wins.
- R9: In the cycle after `cmd_flush`, `ack_valid` is 1 for exactly one cycle with `ack_type` 2'b10. `fifo_empty` is 1 in that cycle, and any pending acknowledge is cancelled.
- R10: From the flush until a cycle with `flush_ack` 1, `preq_ready` is 1 and every request is dropped, so `fifo_empty` stays 1. From the cycle after `flush_ack`, requests are queued again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| preq_valid | input | 1 | Peripheral request valid |
| preq_kind | input | 1 | Request kind: 0 single, 1 burst |
| preq_ready | output | 1 | Request accepted or discarded this cycle |
| cmd_wfb | input | 1 | Start wait-for-burst (one-cycle pulse) |
| cmd_ld_ack | input | 1 | Arm acknowledge on read completion |
| cmd_st_ack | input | 1 | Arm acknowledge on write completion |
| cmd_kind | input | 1 | Kind for the armed acknowledge: 0 single, 1 burst |
| cmd_flush | input | 1 | Flush queue and request resynchronisation |
| rvalid | input | 1 | Read data beat valid |
| rlast | input | 1 | Last beat of read burst |
| bvalid | input | 1 | Write response valid |
| flush_ack | input | 1 | Peripheral answer to the flush request |
| halt | output | 1 | Channel held by wait-for-burst |
| fifo_empty | output | 1 | Request queue empty |
| fifo_full | output | 1 | Request queue full |
| ack_valid | output | 1 | Acknowledge strobe toward peripheral |
| ack_type | output | 2 | 00 single, 01 burst, 10 flush request |

## Verification
The assertions expect every channel command to be a pulse of one cycle. They also expect `cmd_wfb` never to be raised while a wait is already in progress, and `cmd_flush` never to be raised in the same cycle as an arm command. The bench keeps to these rules: each scenario raises one command at a time, drops it after a single clock, and issues each new wait-for-burst only after the previous one has released `halt`. The read-last and write-response inputs are driven in separate cycles, as a bus that returns one completion per cycle would drive them.

// File: rtl/dma_preq_pkg.sv
package dma_preq_pkg;

   typedef enum logic {
      REQ_SINGLE = 1'b0,
      REQ_BURST  = 1'b1
   } req_kind_e;

   localparam int unsigned ACK_TYPE_W = 2;

   localparam logic [ACK_TYPE_W-1:0] ACK_SINGLE = 2'b00;
   localparam logic [ACK_TYPE_W-1:0] ACK_BURST  = 2'b01;
   localparam logic [ACK_TYPE_W-1:0] ACK_FLUSH  = 2'b10;

   // pending completion acknowledge
   typedef struct packed {
      logic armed;
      logic on_write;
      logic kind;
   } ack_slot_t;

endpackage

// File: rtl/dma_preq_fifo.sv
module dma_preq_fifo #(
   parameter int unsigned DEPTH = 4,
   parameter int unsigned WIDTH = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             push,
   input  logic [WIDTH-1:0] push_data,
   input  logic             pop,
   output logic [WIDTH-1:0] head,
   output logic             empty,
   output logic             full
);

   localparam int unsigned AW       = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int unsigned CW       = $clog2(DEPTH + 1);
   localparam bit          POW2     = ((DEPTH & (DEPTH - 1)) == 0);
   localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);
   localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

   initial begin
      if (DEPTH < 2)
         $fatal(1, "dma_preq_fifo: DEPTH must be at least 2");
      if (WIDTH < 1)
         $fatal(1, "dma_preq_fifo: WIDTH must be at least 1");
   end

   logic [WIDTH-1:0] mem [DEPTH];
   logic [AW-1:0]    wr_ptr, rd_ptr;
   logic [AW-1:0]    wr_nxt, rd_nxt;
   logic [CW-1:0]    count;
   logic             do_push, do_pop;

   assign empty   = (count == '0);
   assign full    = (count == FULL_CNT);
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign head    = mem[rd_ptr];

   // pointer advance: free wrap for power-of-two depth, compare otherwise
   generate
      if (POW2) begin : g_wrap_free
         assign wr_nxt = wr_ptr + AW'(1);
         assign rd_nxt = rd_ptr + AW'(1);
      end else begin : g_wrap_cmp
         assign wr_nxt = (wr_ptr == LAST_IDX) ? '0 : wr_ptr + AW'(1);
         assign rd_nxt = (rd_ptr == LAST_IDX) ? '0 : rd_ptr + AW'(1);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_nxt;
         if (do_pop)  rd_ptr <= rd_nxt;
         case ({do_push, do_pop})
            2'b10:   count <= count + CW'(1);
            2'b01:   count <= count - CW'(1);
            default: count <= count;
         endcase
      end
   end

   generate
      for (genvar i = 0; i < DEPTH; i++) begin : g_slot
         always_ff @(posedge clk) begin
            if (!rst_n)
               mem[i] <= '0;
            else if (do_push && wr_ptr == AW'(i))
               mem[i] <= push_data;
         end
      end
   endgenerate

endmodule

// File: rtl/dma_preq_wfb.sv
module dma_preq_wfb
   import dma_preq_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic cmd_wfb,
   input  logic fifo_empty,
   input  logic head_kind,
   output logic pop,
   output logic wait_q,
   output logic halt
);

   logic release_now;

   // while waiting, the head is consumed every cycle it exists
   assign pop         = wait_q && !fifo_empty;
   assign release_now = pop && (head_kind == REQ_BURST);
   assign halt        = wait_q || cmd_wfb;

   always_ff @(posedge clk) begin
      if (!rst_n)
         wait_q <= 1'b0;
      else if (cmd_wfb && !wait_q)
         wait_q <= 1'b1;
      else if (release_now)
         wait_q <= 1'b0;
   end

endmodule

// File: rtl/dma_preq_flush.sv
module dma_preq_flush (
   input  logic clk,
   input  logic rst_n,
   input  logic cmd_flush,
   input  logic flush_ack,
   output logic strobe_q,
   output logic block_q
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         strobe_q <= 1'b0;
         block_q  <= 1'b0;
      end else begin
         strobe_q <= cmd_flush;
         if (cmd_flush)
            block_q <= 1'b1;
         else if (flush_ack)
            block_q <= 1'b0;
      end
   end

endmodule

// File: rtl/dma_preq_ack.sv
module dma_preq_ack
   import dma_preq_pkg::*;
(
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  arm_rd,
   input  logic                  arm_wr,
   input  logic                  arm_kind,
   input  logic                  disarm,
   input  logic                  rvalid,
   input  logic                  rlast,
   input  logic                  bvalid,
   input  logic                  flush_strobe,
   output logic                  ack_valid,
   output logic [ACK_TYPE_W-1:0] ack_type
);

   ack_slot_t slot;
   logic      done_seen;
   logic      fire;

   assign done_seen = slot.on_write ? bvalid : (rvalid && rlast);
   assign fire      = slot.armed && done_seen;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         slot <= '0;
      end else if (disarm) begin
         slot.armed <= 1'b0;
      end else if (arm_rd || arm_wr) begin
         slot.armed    <= 1'b1;
         slot.on_write <= arm_wr;
         slot.kind     <= arm_kind;
      end else if (fire) begin
         slot.armed <= 1'b0;
      end
   end

   always_comb begin
      ack_valid = fire || flush_strobe;
      if (flush_strobe)
         ack_type = ACK_FLUSH;
      else if (slot.kind == REQ_BURST)
         ack_type = ACK_BURST;
      else
         ack_type = ACK_SINGLE;
   end

endmodule

// File: rtl/dma_preq_unit.sv
module dma_preq_unit
   import dma_preq_pkg::*;
#(
   parameter int unsigned REQ_DEPTH = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       preq_valid,
   input  logic       preq_kind,
   output logic       preq_ready,
   input  logic       cmd_wfb,
   input  logic       cmd_ld_ack,
   input  logic       cmd_st_ack,
   input  logic       cmd_kind,
   input  logic       cmd_flush,
   input  logic       rvalid,
   input  logic       rlast,
   input  logic       bvalid,
   input  logic       flush_ack,
   output logic       halt,
   output logic       fifo_empty,
   output logic       fifo_full,
   output logic       ack_valid,
   output logic [1:0] ack_type
);

   initial begin
      if (REQ_DEPTH < 2)
         $fatal(1, "dma_preq_unit: REQ_DEPTH must be at least 2");
      if (ACK_TYPE_W != 2)
         $fatal(1, "dma_preq_unit: acknowledge type must be 2 bits");
   end

   logic wfb_pop;
   logic wfb_active;
   logic head_kind;
   logic flush_strobe;
   logic flush_blocked;
   logic q_push;

   assign preq_ready = flush_blocked || !fifo_full;
   assign q_push     = preq_valid && !fifo_full && !flush_blocked;

   dma_preq_fifo #(
      .DEPTH (REQ_DEPTH),
      .WIDTH (1)
   ) u_fifo (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (cmd_flush),
      .push      (q_push),
      .push_data (preq_kind),
      .pop       (wfb_pop),
      .head      (head_kind),
      .empty     (fifo_empty),
      .full      (fifo_full)
   );

   dma_preq_wfb u_wfb (
      .clk        (clk),
      .rst_n      (rst_n),
      .cmd_wfb    (cmd_wfb),
      .fifo_empty (fifo_empty),
      .head_kind  (head_kind),
      .pop        (wfb_pop),
      .wait_q     (wfb_active),
      .halt       (halt)
   );

   dma_preq_flush u_flush (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_flush (cmd_flush),
      .flush_ack (flush_ack),
      .strobe_q  (flush_strobe),
      .block_q   (flush_blocked)
   );

   dma_preq_ack u_ack (
      .clk          (clk),
      .rst_n        (rst_n),
      .arm_rd       (cmd_ld_ack),
      .arm_wr       (cmd_st_ack),
      .arm_kind     (cmd_kind),
      .disarm       (cmd_flush),
      .rvalid       (rvalid),
      .rlast        (rlast),
      .bvalid       (bvalid),
      .flush_strobe (flush_strobe),
      .ack_valid    (ack_valid),
      .ack_type     (ack_type)
   );

endmodule

// File: rtl/dma_preq_chk.sv
module dma_preq_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       preq_ready,
   input logic       cmd_wfb,
   input logic       cmd_flush,
   input logic       rvalid,
   input logic       rlast,
   input logic       bvalid,
   input logic       halt,
   input logic       fifo_empty,
   input logic       fifo_full,
   input logic       ack_valid,
   input logic [1:0] ack_type,
   input logic       wfb_pop,
   input logic       head_kind,
   input logic       flush_blocked
);

   // R1: status flags never both set
   a_r1_status_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(fifo_empty && fifo_full));

   // R2: full queue pushes back on the peripheral
   a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_full && !flush_blocked) |-> !preq_ready);

   // R3: halt follows the command at once
   a_r3_halt_on_cmd: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_wfb |-> halt);

   // R4: discarding a single keeps the channel halted
   a_r4_single_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (wfb_pop && !head_kind) |=> halt);

   // R5: popping a burst releases the channel
   a_r5_burst_releases: assert property (@(posedge clk) disable iff (!rst_n)
      (wfb_pop && head_kind) |=> (halt == cmd_wfb));

   // R6, R7: completion acknowledge only with a completion handshake
   a_r6_ack_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_valid && ack_type != 2'b10) |-> ((rvalid && rlast) || bvalid));

   // R9: flush request strobe follows the flush command
   a_r9_flush_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_flush |=> (ack_valid && ack_type == 2'b10 && fifo_empty));

   // R9: the flush strobe lasts one cycle
   a_r9_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_valid && ack_type == 2'b10 && !$past(cmd_flush)) |-> 1'b0);

   // R10: nothing enters the queue while blocked
   a_r10_block_empty: assert property (@(posedge clk) disable iff (!rst_n)
      flush_blocked |-> fifo_empty);

endmodule

bind dma_preq_unit dma_preq_chk u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .preq_ready    (preq_ready),
   .cmd_wfb       (cmd_wfb),
   .cmd_flush     (cmd_flush),
   .rvalid        (rvalid),
   .rlast         (rlast),
   .bvalid        (bvalid),
   .halt          (halt),
   .fifo_empty    (fifo_empty),
   .fifo_full     (fifo_full),
   .ack_valid     (ack_valid),
   .ack_type      (ack_type),
   .wfb_pop       (wfb_pop),
   .head_kind     (head_kind),
   .flush_blocked (flush_blocked)
);

// File: tb/dma_preq_unit_test.sv
module dma_preq_unit_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       preq_valid = 1'b0;
   logic       preq_kind = 1'b0;
   logic       preq_ready;
   logic       cmd_wfb = 1'b0;
   logic       cmd_ld_ack = 1'b0;
   logic       cmd_st_ack = 1'b0;
   logic       cmd_kind = 1'b0;
   logic       cmd_flush = 1'b0;
   logic       rvalid = 1'b0;
   logic       rlast = 1'b0;
   logic       bvalid = 1'b0;
   logic       flush_ack = 1'b0;
   logic       halt;
   logic       fifo_empty;
   logic       fifo_full;
   logic       ack_valid;
   logic [1:0] ack_type;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   dma_preq_unit uut (
      .clk        (clk),
      .rst_n      (rst_n),
      .preq_valid (preq_valid),
      .preq_kind  (preq_kind),
      .preq_ready (preq_ready),
      .cmd_wfb    (cmd_wfb),
      .cmd_ld_ack (cmd_ld_ack),
      .cmd_st_ack (cmd_st_ack),
      .cmd_kind   (cmd_kind),
      .cmd_flush  (cmd_flush),
      .rvalid     (rvalid),
      .rlast      (rlast),
      .bvalid     (bvalid),
      .flush_ack  (flush_ack),
      .halt       (halt),
      .fifo_empty (fifo_empty),
      .fifo_full  (fifo_full),
      .ack_valid  (ack_valid),
      .ack_type   (ack_type)
   );

   task automatic chk(input string tag, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // advance past the next rising edge; inputs set before take effect there
   task automatic cyc();
      @(posedge clk);
      #1;
   endtask

   task automatic settle();
      #2;
   endtask

   task automatic push_one(input logic kind);
      preq_valid = 1'b1;
      preq_kind  = kind;
      cyc();
      preq_valid = 1'b0;
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      cyc(); cyc();
      rst_n = 1'b1;
      settle();
      chk("R1 ready", int'(preq_ready), 1);
      chk("R1 empty", int'(fifo_empty), 1);
      chk("R1 full", int'(fifo_full), 0);
      chk("R1 halt", int'(halt), 0);
      chk("R1 ack_valid", int'(ack_valid), 0);
   endtask

   task automatic t_fill_and_drain();
      push_one(1'b0); push_one(1'b0); push_one(1'b1); push_one(1'b1);
      preq_valid = 1'b1; preq_kind = 1'b0;
      settle();
      chk("R2 full after four", int'(fifo_full), 1);
      chk("R2 ready low when full", int'(preq_ready), 0);
      cyc();
      preq_valid = 1'b0;
      settle();
      chk("R2 still full, no overflow", int'(fifo_full), 1);
      cmd_wfb = 1'b1;
      settle();
      chk("R3 halt same cycle", int'(halt), 1);
      cyc();
      cmd_wfb = 1'b0;
      settle();
      chk("R3 halt held", int'(halt), 1);
      cyc(); settle();
      chk("R4 halt after single pop", int'(halt), 1);
      chk("R4 entry removed", int'(fifo_full), 0);
      cyc(); settle();
      chk("R4 halt after second single", int'(halt), 1);
      cyc(); settle();
      chk("R5 halt released after burst", int'(halt), 0);
      chk("R5 one burst remains", int'(fifo_empty), 0);
      cmd_wfb = 1'b1; cyc(); cmd_wfb = 1'b0;
      cyc(); settle();
      chk("R5 last burst released", int'(halt), 0);
      chk("R2 queue drained in order", int'(fifo_empty), 1);
   endtask

   task automatic t_wait_on_empty();
      cmd_wfb = 1'b1; cyc(); cmd_wfb = 1'b0;
      cyc(); settle();
      chk("R3 halt while empty", int'(halt), 1);
      push_one(1'b0);
      cyc(); settle();
      chk("R4 late single discarded, halt", int'(halt), 1);
      chk("R4 late single discarded, empty", int'(fifo_empty), 1);
      push_one(1'b1);
      settle();
      chk("R5 burst present, still halted", int'(halt), 1);
      cyc(); settle();
      chk("R5 halt released", int'(halt), 0);
      chk("R5 burst consumed", int'(fifo_empty), 1);
   endtask

   task automatic t_load_ack();
      cmd_ld_ack = 1'b1; cmd_kind = 1'b1; cyc();
      cmd_ld_ack = 1'b0;
      rvalid = 1'b1; rlast = 1'b0;
      settle();
      chk("R6 no ack without rlast", int'(ack_valid), 0);
      cyc();
      rlast = 1'b1;
      settle();
      chk("R6 ack on rlast", int'(ack_valid), 1);
      chk("R6 burst type 01", int'(ack_type), 1);
      cyc();
      settle();
      chk("R8 spent after fire", int'(ack_valid), 0);
      rvalid = 1'b0; rlast = 1'b0;
      bvalid = 1'b1;
      settle();
      chk("R8 no ack on later bvalid", int'(ack_valid), 0);
      cyc();
      bvalid = 1'b0;
   endtask

   task automatic t_store_ack();
      cmd_st_ack = 1'b1; cmd_kind = 1'b0; cyc();
      cmd_st_ack = 1'b0;
      rvalid = 1'b1; rlast = 1'b1;
      settle();
      chk("R7 rlast ignored for store", int'(ack_valid), 0);
      cyc();
      rvalid = 1'b0; rlast = 1'b0; bvalid = 1'b1;
      settle();
      chk("R7 ack on bvalid", int'(ack_valid), 1);
      chk("R7 single type 00", int'(ack_type), 0);
      cyc();
      bvalid = 1'b0;
   endtask

   task automatic t_rearm();
      cmd_ld_ack = 1'b1; cmd_kind = 1'b0; cyc();
      cmd_ld_ack = 1'b0;
      cmd_st_ack = 1'b1; cmd_kind = 1'b1; cyc();
      cmd_st_ack = 1'b0;
      rvalid = 1'b1; rlast = 1'b1;
      settle();
      chk("R8 replaced load does not fire", int'(ack_valid), 0);
      cyc();
      rvalid = 1'b0; rlast = 1'b0; bvalid = 1'b1;
      settle();
      chk("R8 replacing store fires", int'(ack_valid), 1);
      chk("R8 replacing kind burst", int'(ack_type), 1);
      cyc();
      bvalid = 1'b0;
      cmd_ld_ack = 1'b1; cmd_st_ack = 1'b1; cmd_kind = 1'b0; cyc();
      cmd_ld_ack = 1'b0; cmd_st_ack = 1'b0;
      rvalid = 1'b1; rlast = 1'b1;
      settle();
      chk("R8 store wins tie, rlast ignored", int'(ack_valid), 0);
      cyc();
      rvalid = 1'b0; rlast = 1'b0; bvalid = 1'b1;
      settle();
      chk("R8 store wins tie, bvalid acks", int'(ack_valid), 1);
      cyc();
      bvalid = 1'b0;
   endtask

   task automatic t_flush();
      push_one(1'b1); push_one(1'b0);
      cmd_ld_ack = 1'b1; cmd_kind = 1'b1; cyc();
      cmd_ld_ack = 1'b0;
      cmd_flush = 1'b1; cyc();
      cmd_flush = 1'b0;
      settle();
      chk("R9 flush strobe", int'(ack_valid), 1);
      chk("R9 flush type 10", int'(ack_type), 2);
      chk("R9 queue cleared", int'(fifo_empty), 1);
      cyc(); settle();
      chk("R9 strobe one cycle", int'(ack_valid), 0);
      rvalid = 1'b1; rlast = 1'b1;
      settle();
      chk("R9 pending ack cancelled", int'(ack_valid), 0);
      cyc();
      rvalid = 1'b0; rlast = 1'b0;
      preq_valid = 1'b1; preq_kind = 1'b1;
      settle();
      chk("R10 ready while blocked", int'(preq_ready), 1);
      cyc(); cyc();
      preq_valid = 1'b0;
      settle();
      chk("R10 requests dropped", int'(fifo_empty), 1);
      flush_ack = 1'b1; cyc();
      flush_ack = 1'b0;
      push_one(1'b1);
      settle();
      chk("R10 queued after flush_ack", int'(fifo_empty), 0);
   endtask

   initial begin
      t_reset();
      t_fill_and_drain();
      t_wait_on_empty();
      t_load_ack();
      t_store_ack();
      t_rearm();
      t_flush();
      cyc();
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

endmodule